// File: doc/BRIEF.md
# Paged Short-Address Load/Store Unit

This unit carries out three compact memory instructions for a 16-bit DSP data path. Each instruction holds an 8-bit offset. The other eight address bits come from one of two places. The register load and the register store take their high byte from a writable 8-bit page register. The immediate store always uses page 0xFF, whatever the page register holds. None of the three sign-extends the offset.

The unit holds its own bank of eight 16-bit registers. In the wider register numbering these sit at indices 0x18 to 0x1F, chosen by a 3-bit field in the instruction. A store sends one of these registers to memory in the cycle the instruction is presented. A load issues a read strobe. One cycle later the memory data comes back on `mem_rdata`, and the unit writes it into the bank and shows it on the writeback port. For each instruction the unit also reports how far the program counter must advance.

Top module: `psls_unit`

## Requirements
- R1: After reset the page register holds 0xFF, so `cfg_rd_data` reads 0x00FF. No memory strobe and no writeback is active.
- R2: A page write (`cfg_wr_en`) keeps only bits 7:0 of `cfg_wr_data`. Bits 15:8 of `cfg_rd_data` always read 0.
- R3: A load (`instr_op` = 2'b01) drives `mem_rd` for that one cycle, with `mem_addr` = {page, `instr_off`}.
- R4: A register store (`instr_op` = 2'b10) drives `mem_wr` for that one cycle, with `mem_addr` = {page, `instr_off`} and `mem_wdata` = bank register `instr_reg`.
- R5: An immediate store (`instr_op` = 2'b11) drives `mem_wr` with `mem_addr` = {0xFF, `instr_off`} and `mem_wdata` = `instr_imm`, for any page value.
- R6: An offset of 0x80 or above is never sign-extended. The high address byte is exactly the page, or 0xFF.
- R7: In the cycle after a load, `rf_we` is 1, `rf_idx` = 0x18 + the load's `instr_reg`, and `rf_wdata` = `mem_rdata`. The bank register takes that value.
- R8: `pc_step` is 1 for a load or a register store, 2 for an immediate store, and 0 when no instruction is valid or `instr_op` = 2'b00.
- R9: A page write takes effect from the next cycle. An instruction in the same cycle as the write uses the old page.
- R10: A register store issued in the writeback cycle of a load to the same register stores the returning memory data.
- R11: While `instr_valid` is 0, `mem_rd` and `mem_wr` stay 0 whatever `instr_op` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_op | input | 2 | 00 none, 01 load, 10 register store, 11 immediate store |
| instr_off | input | 8 | Low address byte |
| instr_reg | input | 3 | Bank register select |
| instr_imm | input | 16 | Second instruction word for the immediate store |
| cfg_wr_en | input | 1 | Page register write enable |
| cfg_wr_data | input | 16 | Page write data (bits 7:0 kept) |
| cfg_rd_data | output | 16 | Page register read value |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| pc_step | output | 2 | Program counter increment |
| rf_we | output | 1 | Writeback strobe |
| rf_idx | output | 5 | Writeback register index |
| rf_wdata | output | 16 | Writeback data |

## Verification
The hardest case to reach from the ports is the overlap of a page write, a load and a store. In that case the address must come from the page value before the write, and the store data must come from a load whose writeback has not yet landed in the bank. The stimulus table reaches this case directly. It puts a page write and a load in the same cycle, then issues a store to the same register in the next cycle. The expected address is the old page, and the expected data is the value the memory model returns. A further directed reset, applied while a load is pending, checks that the late return is dropped.

// File: rtl/psls_pkg.sv
// Shared widths, encodings and constants for the paged short-address
// load/store unit. Assumes a 16-bit data path with 16-bit addresses.
package psls_pkg;
    localparam int DATA_W    = 16;
    localparam int OFF_W     = 8;
    localparam int PAGE_W    = DATA_W - OFF_W;
    localparam int SEL_W     = 3;
    localparam int NREG      = 1 << SEL_W;
    localparam int RF_IDX_W  = 5;
    localparam logic [RF_IDX_W-1:0] RF_BASE    = 5'h18;
    localparam logic [PAGE_W-1:0]   PAGE_RESET = 8'hFF;
    localparam logic [PAGE_W-1:0]   FIXED_PAGE = 8'hFF;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_STIMM = 2'b11
    } op_e;
endpackage

// File: rtl/psls_page_reg.sv
// Page register: keeps the low PAGE_W bits of each write and reads back
// zero-extended. Assumes PAGE_W < DATA_W. Synchronous active-low reset.
module psls_page_reg #(
    parameter int DATA_W = 16,
    parameter int PAGE_W = 8,
    parameter logic [PAGE_W-1:0] RESET_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PAGE_W-1:0] page_q,
    output logic [DATA_W-1:0] rd_data
);
    logic unused_hi;

    // The upper write bits are deliberately dropped.
    assign unused_hi = ^wr_data[DATA_W-1:PAGE_W];

    // Hold the page, loading the low bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= RESET_VAL;
        else if (wr_en)
            page_q <= wr_data[PAGE_W-1:0];
    end

    // Zero-extend for the read port.
    assign rd_data = {{(DATA_W-PAGE_W){1'b0}}, page_q};
endmodule

// File: rtl/psls_addr_gen.sv
// Address former: joins a high byte with the instruction offset. The
// immediate store uses a fixed page; other ops use the page register.
// No sign extension is applied to the offset.
module psls_addr_gen
    import psls_pkg::*;
#(
    parameter int PW = PAGE_W,
    parameter int OW = OFF_W,
    parameter logic [PW-1:0] FIXED = '1
) (
    input  op_e             op,
    input  logic [PW-1:0]   page,
    input  logic [OW-1:0]   off,
    output logic [PW+OW-1:0] addr
);
    logic [PW-1:0] hi;

    // Choose the high byte by instruction form.
    always_comb begin
        if (op == OP_STIMM)
            hi = FIXED;
        else
            hi = page;
    end

    // Plain concatenation: offset bits never reach the high byte.
    assign addr = {hi, off};
endmodule

// File: rtl/psls_regbank.sv
// Bank of NREG registers with one write port and one combinational read
// port. Write and read in the same cycle return the old value.
module psls_regbank #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    localparam int SW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SW-1:0]     rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Each register loads when selected for writeback.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_sel == SW'(g))
                regs[g] <= wr_data;
        end
    end

    // Read mux.
    assign rd_data = regs[rd_sel];
endmodule

// File: rtl/psls_unit.sv
// Top of the paged short-address load/store unit. Decodes the three
// short instruction forms, drives memory strobes in the issue cycle, and
// completes loads one cycle later when memory data returns. Assumes the
// memory delivers read data exactly one cycle after mem_rd.
module psls_unit
    import psls_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [1:0]          instr_op,
    input  logic [OFF_W-1:0]    instr_off,
    input  logic [SEL_W-1:0]    instr_reg,
    input  logic [DATA_W-1:0]   instr_imm,
    input  logic                cfg_wr_en,
    input  logic [DATA_W-1:0]   cfg_wr_data,
    output logic [DATA_W-1:0]   cfg_rd_data,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [1:0]          pc_step,
    output logic                rf_we,
    output logic [RF_IDX_W-1:0] rf_idx,
    output logic [DATA_W-1:0]   rf_wdata
);
    op_e               op;
    logic              is_ld, is_st, is_si;
    logic [PAGE_W-1:0] page;
    logic              pend;
    logic [SEL_W-1:0]  pend_sel;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] st_data;

    // Decode the valid instruction form.
    always_comb begin
        op    = instr_valid ? op_e'(instr_op) : OP_NONE;
        is_ld = (op == OP_LOAD);
        is_st = (op == OP_STORE);
        is_si = (op == OP_STIMM);
    end

    psls_page_reg #(
        .DATA_W   (DATA_W),
        .PAGE_W   (PAGE_W),
        .RESET_VAL(PAGE_RESET)
    ) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_data(cfg_wr_data),
        .page_q (page),
        .rd_data(cfg_rd_data)
    );

    psls_addr_gen #(
        .PW   (PAGE_W),
        .OW   (OFF_W),
        .FIXED(FIXED_PAGE)
    ) u_addr (
        .op  (op),
        .page(page),
        .off (instr_off),
        .addr(mem_addr)
    );

    psls_regbank #(
        .NREG  (NREG),
        .DATA_W(DATA_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pend),
        .wr_sel (pend_sel),
        .wr_data(mem_rdata),
        .rd_sel (instr_reg),
        .rd_data(bank_rd)
    );

    // Track a load whose data returns next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_sel <= '0;
        end else begin
            pend     <= is_ld;
            pend_sel <= instr_reg;
        end
    end

    // Store source, forwarding a returning load to the same register.
    always_comb begin
        if (pend && pend_sel == instr_reg)
            st_data = mem_rdata;
        else
            st_data = bank_rd;
    end

    // Memory strobes and write data.
    always_comb begin
        mem_rd = is_ld;
        mem_wr = is_st || is_si;
        if (is_si)
            mem_wdata = instr_imm;
        else if (is_st)
            mem_wdata = st_data;
        else
            mem_wdata = '0;
    end

    // Program counter increment per form.
    always_comb begin
        if (is_si)
            pc_step = 2'd2;
        else if (is_ld || is_st)
            pc_step = 2'd1;
        else
            pc_step = 2'd0;
    end

    // Writeback port.
    always_comb begin
        rf_we    = pend;
        rf_idx   = pend ? RF_BASE + {{(RF_IDX_W-SEL_W){1'b0}}, pend_sel} : '0;
        rf_wdata = pend ? mem_rdata : '0;
    end
endmodule

// File: rtl/psls_unit_chk.sv
// Assertion checker for psls_unit, attached through bind. Relates the
// instruction inputs to the memory, page and writeback ports over time.
module psls_unit_chk
    import psls_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                instr_valid,
    input logic [1:0]          instr_op,
    input logic [OFF_W-1:0]    instr_off,
    input logic [SEL_W-1:0]    instr_reg,
    input logic [DATA_W-1:0]   instr_imm,
    input logic                cfg_wr_en,
    input logic [DATA_W-1:0]   cfg_wr_data,
    input logic [DATA_W-1:0]   cfg_rd_data,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic [DATA_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic [DATA_W-1:0]   mem_rdata,
    input logic [1:0]          pc_step,
    input logic                rf_we,
    input logic [RF_IDX_W-1:0] rf_idx,
    input logic [DATA_W-1:0]   rf_wdata
);
    logic seen;

    // Marks cycles whose predecessor was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[DATA_W-1:PAGE_W] == '0);

    p_load_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_op == 2'b01) |->
            (mem_rd && !mem_wr && mem_addr == {cfg_rd_data[PAGE_W-1:0], instr_off}));

    p_store_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_op == 2'b10) |->
            (mem_wr && !mem_rd && mem_addr == {cfg_rd_data[PAGE_W-1:0], instr_off}));

    p_imm_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_op == 2'b11) |->
            (mem_wr && mem_addr == {8'hFF, instr_off} && mem_wdata == instr_imm));

    p_writeback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(instr_valid && instr_op == 2'b01)) |->
            (rf_we && rf_idx == RF_BASE + {2'b00, $past(instr_reg)} && rf_wdata == mem_rdata));

    p_no_stray_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(instr_valid && instr_op == 2'b01)) |-> !rf_we);

    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid || instr_op == 2'b00) |-> pc_step == 2'd0);

    p_cfg_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(cfg_wr_en)) |->
            cfg_rd_data[PAGE_W-1:0] == $past(cfg_wr_data[PAGE_W-1:0]));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(cfg_wr_en)) |-> $stable(cfg_rd_data));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (!mem_rd && !mem_wr));

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind psls_unit psls_unit_chk chk (.*);

// File: tb/psls_unit_test.sv
`timescale 1ns/1ps
module psls_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [1:0]  instr_op = 2'b00;
    logic [7:0]  instr_off = 8'h00;
    logic [2:0]  instr_reg = 3'd0;
    logic [15:0] instr_imm = 16'h0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = 16'h0;
    logic [15:0] cfg_rd_data;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [1:0]  pc_step;
    logic        rf_we;
    logic [4:0]  rf_idx;
    logic [15:0] rf_wdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    psls_unit uut (.*);

    // Behavioural memory: one-cycle read latency, sparse storage.
    logic [15:0] bmem [logic [15:0]];
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= bmem.exists(mem_addr) ? bmem[mem_addr] : 16'h0;
        if (mem_wr)
            bmem[mem_addr] = mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Vector: page write, instruction, hand-computed address and pc step.
    typedef struct packed {
        logic        cwe;
        logic [15:0] cd;
        logic [1:0]  op;
        logic [7:0]  off;
        logic [2:0]  sel;
        logic [15:0] imm;
        logic [15:0] ea;
        logic [1:0]  epc;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0000, 2'b11, 8'hA0, 3'd0, 16'hF00F, 16'hFFA0, 2'd2},
        '{1'b1, 16'h1200, 2'b01, 8'hA0, 3'd3, 16'h0000, 16'hFFA0, 2'd1},
        '{1'b0, 16'h0000, 2'b10, 8'hA0, 3'd3, 16'h0000, 16'h00A0, 2'd1},
        '{1'b1, 16'hAB01, 2'b00, 8'h00, 3'd0, 16'h0000, 16'h0000, 2'd0},
        '{1'b0, 16'h0000, 2'b10, 8'hA0, 3'd3, 16'h0000, 16'h01A0, 2'd1},
        '{1'b0, 16'h0000, 2'b11, 8'h80, 3'd0, 16'h5A5A, 16'hFF80, 2'd2},
        '{1'b1, 16'h00FF, 2'b00, 8'h00, 3'd0, 16'h0000, 16'h0000, 2'd0},
        '{1'b0, 16'h0000, 2'b01, 8'h80, 3'd0, 16'h0000, 16'hFF80, 2'd1},
        '{1'b0, 16'h0000, 2'b10, 8'h7F, 3'd0, 16'h0000, 16'hFF7F, 2'd1},
        '{1'b1, 16'h0080, 2'b00, 8'h00, 3'd0, 16'h0000, 16'h0000, 2'd0},
        '{1'b0, 16'h0000, 2'b11, 8'hFF, 3'd1, 16'hBEEF, 16'hFFFF, 2'd2},
        '{1'b0, 16'h0000, 2'b01, 8'hA0, 3'd7, 16'h0000, 16'h80A0, 2'd1},
        '{1'b1, 16'h0000, 2'b00, 8'h00, 3'd0, 16'h0000, 16'h0000, 2'd0},
        '{1'b0, 16'h0000, 2'b01, 8'hA0, 3'd5, 16'h0000, 16'h00A0, 2'd1},
        '{1'b0, 16'h0000, 2'b00, 8'h00, 3'd0, 16'h0000, 16'h0000, 2'd0},
        '{1'b0, 16'h0000, 2'b10, 8'h10, 3'd5, 16'h0000, 16'h0010, 2'd1},
        '{1'b1, 16'h0001, 2'b10, 8'hA0, 3'd5, 16'h0000, 16'h00A0, 2'd1},
        '{1'b0, 16'h0000, 2'b01, 8'hA0, 3'd2, 16'h0000, 16'h01A0, 2'd1}
    };

    // Requirement-level model of the page, bank and memory contents.
    logic [7:0]  m_page;
    logic [15:0] m_reg [8];
    logic [15:0] m_mem [logic [15:0]];
    bit          m_pend;
    logic [4:0]  m_pidx;
    logic [15:0] m_pdata;

    function automatic logic [15:0] m_rd(input logic [15:0] a);
        return m_mem.exists(a) ? m_mem[a] : 16'h0;
    endfunction

    task automatic check_wb();
        if (m_pend) begin
            chk(rf_we == 1'b1, "R7 rf_we", rf_we, 1);
            chk(rf_idx == m_pidx, "R7 rf_idx", rf_idx, m_pidx);
            chk(rf_wdata == m_pdata, "R7 rf_wdata", rf_wdata, m_pdata);
        end else begin
            chk(rf_we == 1'b0, "R7 no writeback", rf_we, 0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] exp_wd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        chk(cfg_rd_data == 16'h00FF, "R1 page reset", cfg_rd_data, 16'h00FF);
        chk(!mem_rd && !mem_wr, "R1 no strobes", {mem_rd, mem_wr}, 0);
        chk(rf_we == 1'b0, "R1 no writeback", rf_we, 0);

        m_page = 8'hFF;
        for (int k = 0; k < 8; k++) m_reg[k] = 16'h0;
        m_pend = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr_valid = (VEC[i].op != 2'b00);
            instr_op    = VEC[i].op;
            instr_off   = VEC[i].off;
            instr_reg   = VEC[i].sel;
            instr_imm   = VEC[i].imm;
            cfg_wr_en   = VEC[i].cwe;
            cfg_wr_data = VEC[i].cd;
            #1;
            check_wb();
            // R2/R9: page visible now is the one before this cycle's write.
            chk(cfg_rd_data == {8'h00, m_page}, "R2 R9 page readback",
                cfg_rd_data, {8'h00, m_page});
            chk(pc_step == VEC[i].epc, "R8 pc_step", pc_step, VEC[i].epc);
            chk(mem_rd == (VEC[i].op == 2'b01), "R3 read strobe", mem_rd,
                VEC[i].op == 2'b01);
            chk(mem_wr == (VEC[i].op[1]), "R4 R5 write strobe", mem_wr, VEC[i].op[1]);
            if (VEC[i].op != 2'b00)
                chk(mem_addr == VEC[i].ea, "R3 R4 R5 R6 address", mem_addr, VEC[i].ea);
            if (VEC[i].op == 2'b11)
                exp_wd = VEC[i].imm;
            else
                exp_wd = m_reg[VEC[i].sel];
            if (VEC[i].op == 2'b10)
                chk(mem_wdata == exp_wd, "R4 R10 store data", mem_wdata, exp_wd);
            if (VEC[i].op == 2'b11)
                chk(mem_wdata == exp_wd, "R5 immediate data", mem_wdata, exp_wd);
            // Advance the model.
            m_pend = (VEC[i].op == 2'b01);
            if (VEC[i].op == 2'b01) begin
                m_pidx  = 5'h18 + {2'b00, VEC[i].sel};
                m_pdata = m_rd(VEC[i].ea);
                m_reg[VEC[i].sel] = m_pdata;
            end
            if (VEC[i].op[1])
                m_mem[VEC[i].ea] = exp_wd;
            if (VEC[i].cwe)
                m_page = VEC[i].cd[7:0];
        end

        // Drain the final load.
        @(negedge clk);
        instr_valid = 1'b0; instr_op = 2'b00; cfg_wr_en = 1'b0;
        #1;
        check_wb();
        m_pend = 1'b0;

        // R11: op held as store and immediate store while not valid.
        @(negedge clk);
        instr_valid = 1'b0; instr_op = 2'b10; instr_off = 8'h33;
        #1;
        chk(!mem_rd && !mem_wr, "R11 idle store", {mem_rd, mem_wr}, 0);
        chk(pc_step == 2'd0, "R8 R11 idle pc", pc_step, 0);
        @(negedge clk);
        instr_op = 2'b11;
        #1;
        chk(!mem_rd && !mem_wr, "R11 idle stimm", {mem_rd, mem_wr}, 0);
        @(negedge clk);
        instr_op = 2'b01;
        #1;
        chk(!mem_rd && !mem_wr, "R11 idle load", {mem_rd, mem_wr}, 0);
        @(negedge clk);
        #1;
        chk(rf_we == 1'b0, "R11 no writeback from idle load", rf_we, 0);

        // R1: reset while a load is outstanding.
        @(negedge clk);
        instr_valid = 1'b1; instr_op = 2'b01; instr_off = 8'hA0; instr_reg = 3'd4;
        @(negedge clk);
        instr_valid = 1'b0; instr_op = 2'b00;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(rf_we == 1'b0, "R1 reset drops writeback", rf_we, 0);
        chk(cfg_rd_data == 16'h00FF, "R1 page back to FF", cfg_rd_data, 16'h00FF);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 negative: stored bank register 4 was cleared, load discarded.
        instr_valid = 1'b1; instr_op = 2'b10; instr_off = 8'h01; instr_reg = 3'd4;
        #1;
        chk(mem_wdata == 16'h0, "R1 R7 bank cleared", mem_wdata, 0);
        chk(mem_addr == 16'hFF01, "R1 R4 reset page address", mem_addr, 16'hFF01);
        @(negedge clk);
        instr_valid = 1'b0; instr_op = 2'b00;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule